// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block sits in front of a DRAM command port and decides, one cycle at a time, which way a single shared data bus is pointed. Incoming reads wait in a small read queue. Incoming writes wait in a write buffer. The block hands one command at a time to the downstream port over a valid/ready handshake. Writes are normally held back so that the bus keeps serving reads. The buffered writes then go out in bursts, so the bus reverses direction as seldom as possible.

Two water marks on the write buffer set the burst. When the occupancy climbs to the high mark, the block reverses the bus and drains writes back to back. The drain ends when the occupancy has fallen to the low mark, and reads are then served again. Each reversal costs a fixed number of idle turnaround cycles. If no read is waiting, the block switches to writes early and pays the same cost. A read to an address that still sits in the write buffer waits until that write has gone out.

Top module: `rw_turn_arbiter`

## Requirements
- R1: After reset, `cmd_valid` is low and both `rd_ready` and `wr_ready` are high.
- R2: Reads leave in arrival order with their address unchanged. Writes leave in arrival order with address and data unchanged. `cmd_is_wr` is 1 for a write and 0 for a read, and a command is presented only when its queue holds an entry.
- R3: While fewer than `HI_MARK` writes are buffered and a read that can issue is waiting, every waiting read is issued before any write.
- R4: When write occupancy reaches `HI_MARK`, the block turns to writes and issues them back to back until occupancy equals `LO_MARK`. It then turns to reads if a read is waiting. No read is accepted while occupancy is at or above `HI_MARK`.
- R5: With the read queue empty and writes buffered, the block turns to writes without waiting for the high mark.
- R6: Every change of direction leaves exactly `TURN_CYC`+1 cycles with `cmd_valid` low: one decision cycle and `TURN_CYC` turnaround cycles. Between the acceptance of the last command in one direction and the first command in the other, with `cmd_ready` held high, `TURN_CYC`+2 cycles pass.
- R7: `wr_ready` is low while `WR_DEPTH` writes are buffered, and a write offered then is dropped. `rd_ready` is low while `RD_DEPTH` reads are queued.
- R8: A read whose address equals the address of a buffered write is issued only after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue can take a request |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write buffer can take a request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| cmd_valid | output | 1 | Command presented downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_is_wr | output | 1 | 1 for a write command, 0 for a read |
| cmd_addr | output | AW | Command address |
| cmd_data | output | DW | Write data; zero for reads |

## Verification
A request accepted at a clock edge becomes visible to the control logic in the next cycle. A direction change takes one decision cycle plus `TURN_CYC` turnaround cycles. The first command in the new direction is therefore accepted `TURN_CYC`+2 edges after the last command in the old one. The bench holds `cmd_ready` low while it loads each scenario, waits long enough for any reversal to settle, and then raises `cmd_ready`. It logs every accepted command with its cycle number, sampled on the falling edge. It compares each command with its scoreboard queue, checks the order of directions against the expected pattern, and checks the exact cycle distance at each reversal.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;

    // Bus direction mode of the arbiter
    typedef enum logic [1:0] {
        MODE_RD    = 2'd0,
        MODE_WR    = 2'd1,
        MODE_TO_WR = 2'd2,
        MODE_TO_RD = 2'd3
    } mode_e;

endpackage

// File: rtl/rwarb_fifo.sv
module rwarb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
        if (push_ok) mem[st_q.wp] <= din;
    end
endmodule

// File: rtl/rwarb_wbuf.sv
module rwarb_wbuf #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    input  logic [AW-1:0] match_addr,
    output logic          match_hit
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0]    wp;
        logic [PW-1:0]    rp;
        logic [CW-1:0]    cnt;
        logic [DEPTH-1:0] occ;
    } wbuf_st_t;

    wbuf_st_t st_q, st_d;
    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic push_ok, pop_ok;

    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && !empty;
    assign head_addr = addr_mem[st_q.rp];
    assign head_data = data_mem[st_q.rp];

    // Per-entry address compare against occupied slots
    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign hit_vec[i] = st_q.occ[i] && (addr_mem[i] == match_addr);
    end
    assign match_hit = |hit_vec;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.occ[st_q.wp] = 1'b1;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop_ok) begin
            st_d.occ[st_q.rp] = 1'b0;
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
        if (push_ok) begin
            addr_mem[st_q.wp] <= push_addr;
            data_mem[st_q.wp] <= push_data;
        end
    end
endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
    import rwarb_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 8,
    parameter int HI_MARK  = 6,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_is_wr,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);
    localparam int WCW = $clog2(WR_DEPTH + 1);
    localparam int TW  = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;

    typedef struct packed {
        mode_e         mode;
        logic          drain;
        logic [TW-1:0] tmr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [AW-1:0]  rd_head, wr_head_addr;
    logic [DW-1:0]  wr_head_data;
    logic [WCW-1:0] wr_cnt;
    logic rd_full, rd_empty, wr_full, wr_empty, hazard;
    logic rd_pop, wr_pop, drain_now, rd_ok;

    assign rd_ready = !rd_full;
    assign wr_ready = !wr_full;

    rwarb_fifo #(.W(AW), .DEPTH(RD_DEPTH)) u_rdq (
        .clk(clk), .rst_n(rst_n),
        .push(rd_valid && rd_ready), .din(rd_addr),
        .pop(rd_pop), .dout(rd_head),
        .full(rd_full), .empty(rd_empty)
    );

    rwarb_wbuf #(.AW(AW), .DW(DW), .DEPTH(WR_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(wr_valid && wr_ready), .push_addr(wr_addr), .push_data(wr_data),
        .pop(wr_pop), .head_addr(wr_head_addr), .head_data(wr_head_data),
        .count(wr_cnt), .full(wr_full), .empty(wr_empty),
        .match_addr(rd_head), .match_hit(hazard)
    );

    // Hysteresis: drain holds from the high mark down to the low mark
    assign drain_now = (wr_cnt >= WCW'(HI_MARK)) ||
                       (ctl_q.drain && (wr_cnt > WCW'(LO_MARK)));
    assign rd_ok     = !rd_empty && !hazard;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.drain = drain_now;
        cmd_valid   = 1'b0;
        cmd_is_wr   = 1'b0;
        cmd_addr    = rd_head;
        cmd_data    = '0;
        rd_pop      = 1'b0;
        wr_pop      = 1'b0;
        unique case (ctl_q.mode)
            MODE_RD: begin
                if (drain_now || (!rd_ok && !wr_empty)) begin
                    ctl_d.mode = MODE_TO_WR;
                    ctl_d.tmr  = TW'(TURN_CYC - 1);
                end else begin
                    cmd_valid = rd_ok;
                    rd_pop    = rd_ok && cmd_ready;
                end
            end
            MODE_WR: begin
                cmd_is_wr = 1'b1;
                cmd_addr  = wr_head_addr;
                cmd_data  = wr_head_data;
                if (!drain_now && rd_ok) begin
                    ctl_d.mode = MODE_TO_RD;
                    ctl_d.tmr  = TW'(TURN_CYC - 1);
                end else begin
                    cmd_valid = !wr_empty;
                    wr_pop    = !wr_empty && cmd_ready;
                end
            end
            MODE_TO_WR: begin
                if (ctl_q.tmr == '0) ctl_d.mode = MODE_WR;
                else                 ctl_d.tmr  = ctl_q.tmr - 1'b1;
            end
            default: begin
                if (ctl_q.tmr == '0) ctl_d.mode = MODE_RD;
                else                 ctl_d.tmr  = ctl_q.tmr - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{mode: MODE_RD, drain: 1'b0, tmr: '0};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/rwarb_chk.sv
module rwarb_chk #(
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 8,
    parameter int HI_MARK  = 6,
    parameter int TURN_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rd_valid,
    input logic rd_ready,
    input logic wr_valid,
    input logic wr_ready,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_is_wr
);
    localparam int RCW = $clog2(RD_DEPTH + 1);
    localparam int WCW = $clog2(WR_DEPTH + 1);
    localparam int GW  = $clog2(TURN_CYC + 3);

    logic [RCW-1:0] rocc_q;
    logic [WCW-1:0] wocc_q;
    logic [GW-1:0]  gap_q;
    logic have_last_q, last_wr_q;
    logic acc, rd_in, wr_in;

    assign acc   = cmd_valid && cmd_ready;
    assign rd_in = rd_valid && rd_ready;
    assign wr_in = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rocc_q <= '0; wocc_q <= '0; gap_q <= '0;
            have_last_q <= 1'b0; last_wr_q <= 1'b0;
        end else begin
            rocc_q <= rocc_q + RCW'(rd_in) - RCW'(acc && !cmd_is_wr);
            wocc_q <= wocc_q + WCW'(wr_in) - WCW'(acc && cmd_is_wr);
            if (acc) begin
                have_last_q <= 1'b1;
                last_wr_q   <= cmd_is_wr;
                gap_q       <= '0;
            end else if (gap_q != GW'(TURN_CYC + 1)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R6: the opposite direction waits out the turnaround
    a_r6_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && have_last_q && (cmd_is_wr != last_wr_q)) |-> (gap_q == GW'(TURN_CYC + 1)));

    // R7: full write buffer refuses input
    a_r7_wr_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wocc_q == WCW'(WR_DEPTH)) |-> !wr_ready);

    // R7: full read queue refuses input
    a_r7_rd_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rocc_q == RCW'(RD_DEPTH)) |-> !rd_ready);

    // R4: no read accepted at or above the high mark
    a_r4_no_read_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_is_wr) |-> (wocc_q < WCW'(HI_MARK)));

    // R2: a command only comes from a non-empty queue
    a_r2_src_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_is_wr ? (wocc_q != '0) : (rocc_q != '0)));
endmodule

bind rw_turn_arbiter rwarb_chk #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .HI_MARK(HI_MARK), .TURN_CYC(TURN_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_wr(cmd_is_wr)
);

// File: tb/test_rw_turn_arbiter.sv
module test_rw_turn_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 16, RD_DEPTH = 4, WR_DEPTH = 8;
    localparam int HI_MARK = 6, LO_MARK = 2, TURN_CYC = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_valid = 1'b0, wr_valid = 1'b0, cmd_ready = 1'b0;
    logic rd_ready, wr_ready, cmd_valid, cmd_is_wr;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0, cmd_addr;
    logic [DW-1:0] wr_data = '0, cmd_data;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    logic [AW-1:0]      exp_rd[$];
    logic [AW+DW-1:0]   exp_wr[$];
    string dir_log = "";
    int    cyc_log[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rw_turn_arbiter #(.AW(AW), .DW(DW), .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH),
        .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .TURN_CYC(TURN_CYC)) i_rw_turn_arbiter (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_wr(cmd_is_wr),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_str(input string req, input string act, input string exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // Monitor and scoreboard: sample away from the rising edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cmd_valid && cmd_ready) begin
            dir_log = {dir_log, cmd_is_wr ? "W" : "R"};
            cyc_log.push_back(cyc);
            if (cmd_is_wr) begin
                if (exp_wr.size() == 0) check(0, "R2 unexpected write", int'(cmd_addr), -1);
                else begin
                    logic [AW+DW-1:0] e;
                    e = exp_wr.pop_front();
                    check({cmd_addr, cmd_data} == e, "R2 write order", int'({cmd_addr, cmd_data}), int'(e));
                end
            end else begin
                if (exp_rd.size() == 0) check(0, "R2 unexpected read", int'(cmd_addr), -1);
                else begin
                    logic [AW-1:0] e;
                    e = exp_rd.pop_front();
                    check(cmd_addr == e, "R2 read order", int'(cmd_addr), int'(e));
                    check(cmd_data == '0, "R2 read data zero", int'(cmd_data), 0);
                end
            end
        end
    end

    task automatic push_rd(input logic [AW-1:0] a);
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        exp_rd.push_back(a);
        @(posedge clk); #1;
        rd_valid = 1'b0;
    endtask

    task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        exp_wr.push_back({a, d});
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3 * TURN_CYC + 10) @(posedge clk);
    endtask

    task automatic run_out(input int n);
        dir_log = "";
        cyc_log.delete();
        @(posedge clk); #1;
        cmd_ready = 1'b1;
        for (int k = 0; k < 300 && dir_log.len() < n; k++) @(posedge clk);
        repeat (8) @(posedge clk);
        #1 cmd_ready = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string exp_s;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
        check(rd_ready == 1'b1, "R1 rd_ready", int'(rd_ready), 1);
        check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);

        // R2: reads only
        push_rd(8'h10); push_rd(8'h11); push_rd(8'h12);
        run_out(3);
        check_str("R2 reads only", dir_log, "RRR");

        // R3/R5/R6: reads before sub-threshold writes, then early switch
        for (int i = 0; i < RD_DEPTH; i++) push_rd(AW'(8'h20 + i));
        @(negedge clk);
        check(rd_ready == 1'b0, "R7 read queue full", int'(rd_ready), 0);
        for (int i = 0; i < 3; i++) push_wr(AW'(8'h30 + i), DW'(16'h1000 + i));
        settle();
        run_out(7);
        check_str("R3 R5 reads first", dir_log, "RRRRWWW");
        if (cyc_log.size() >= 5)
            check(cyc_log[4] - cyc_log[3] == TURN_CYC + 2, "R6 gap R to W",
                  cyc_log[4] - cyc_log[3], TURN_CYC + 2);

        // R4: high mark triggers a drain down to the low mark
        for (int i = 0; i < RD_DEPTH; i++) push_rd(AW'(8'h40 + i));
        settle();
        for (int i = 0; i < HI_MARK; i++) push_wr(AW'(8'h50 + i), DW'(16'h2000 + i));
        settle();
        run_out(RD_DEPTH + HI_MARK);
        exp_s = "";
        for (int i = 0; i < HI_MARK - LO_MARK; i++) exp_s = {exp_s, "W"};
        for (int i = 0; i < RD_DEPTH; i++) exp_s = {exp_s, "R"};
        for (int i = 0; i < LO_MARK; i++) exp_s = {exp_s, "W"};
        check_str("R4 drain burst", dir_log, exp_s);
        if (cyc_log.size() > HI_MARK - LO_MARK)
            check(cyc_log[HI_MARK-LO_MARK] - cyc_log[HI_MARK-LO_MARK-1] == TURN_CYC + 2,
                  "R6 gap W to R", cyc_log[HI_MARK-LO_MARK] - cyc_log[HI_MARK-LO_MARK-1], TURN_CYC + 2);

        // R8: read to a buffered write address waits for it
        push_wr(8'h55, 16'hBEEF);
        push_rd(8'h55);
        settle();
        run_out(2);
        check_str("R8 hazard order", dir_log, "WR");

        // R8 contrast: different address, read goes first
        push_wr(8'h66, 16'hCAFE);
        settle();
        push_rd(8'h77);
        settle();
        run_out(2);
        check_str("R8 no hazard order", dir_log, "RW");

        // R7: full write buffer, extra write dropped
        for (int i = 0; i < WR_DEPTH; i++) push_wr(AW'(8'h80 + i), DW'(16'h3000 + i));
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 8'hEE; wr_data = 16'hDEAD;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(wr_ready == 1'b0, "R7 write buffer full", int'(wr_ready), 0);
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
        run_out(WR_DEPTH + 1);
        exp_s = "";
        for (int i = 0; i < WR_DEPTH; i++) exp_s = {exp_s, "W"};
        check_str("R7 dropped write", dir_log, exp_s);
        @(negedge clk);
        check(wr_ready == 1'b1, "R7 ready after drain", int'(wr_ready), 1);
        check(exp_rd.size() == 0 && exp_wr.size() == 0, "R2 queues empty",
              exp_rd.size() + exp_wr.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule